// File: doc/BRIEF.md
# Buffered Input Capture Unit

This block timestamps transitions on an external signal against a free-running 16-bit counter. The signal first passes through a synchronizer. A selectable edge qualifier then decides which transitions count. Each qualifying transition loads the current count into a capture register.

When buffering is switched on, the same event moves the previous capture value into a second register. Software can therefore read two consecutive timestamps at once, for example to measure a pulse width or a period without racing the next edge.

A single-cycle event strobe marks every capture. A sticky status bit stays set until a write-one clear arrives.

Top module: `icap_buffered`

## Requirements
- R1: `cnt_o` increases by one on every clock after reset and wraps from 0xFFFF to 0x0000.
- R2: While `rst_i` is high, `cnt_o`, `cap_o`, `buf_o`, `evt_o` and `seen_o` are all zero.
- R3: `pin_i` passes through two synchronizing flops. A change driven on `pin_i` in the cycle where `cnt_o` shows value c results in `cap_o` = c+2, visible after the third rising clock edge following the change.
- R4: `edge_sel_i` encoding: 2'b00 captures on rising edges only, 2'b01 on falling edges only, 2'b10 on both edges, 2'b11 never captures.
- R5: With `buf_en_i` = 1 at a capture, `buf_o` takes the value `cap_o` held just before that capture.
- R6: With `buf_en_i` = 0 at a capture, `buf_o` keeps its value while `cap_o` still updates.
- R7: `evt_o` is high for exactly one cycle per capture, in the same cycle that the new value first appears on `cap_o`.
- R8: `seen_o` is set by a capture and cleared by `clr_i` held high for one cycle. If a capture and a clear coincide, the set wins.
- R9: A transition that does not qualify under the current `edge_sel_i` leaves `cap_o`, `buf_o` and `evt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous capture signal |
| edge_sel_i | input | 2 | Edge qualifier select |
| buf_en_i | input | 1 | Enables the shift into the buffer register |
| clr_i | input | 1 | Write-one clear of the sticky status |
| cnt_o | output | 16 | Free-running count |
| cap_o | output | 16 | Latest captured count |
| buf_o | output | 16 | Previous captured count (buffer) |
| evt_o | output | 1 | One-cycle capture strobe |
| seen_o | output | 1 | Sticky capture status |

## Verification
The hardest situations to reach from the ports are a capture landing on chosen counter values and a clear arriving in exactly the capture cycle. Both depend on the two-flop latency. The stimulus polls `cnt_o` on falling edges and toggles the pin when the count is two below the target. It raises the clear on the second falling edge after a toggle, so that the clear meets the event. A table run walks every edge mode against both pin levels and both buffer settings. Counts 0x0245, 0x5480 and 0xDA91 are then captured in turn, and the run continues through the counter wrap.

// File: rtl/icap_pkg.sv
package icap_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_OFF  = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad
      $error("icap_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= '0;
      else       chain_q <= {chain_q[LAST-1:0], d_i};
   end

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/icap_edge.sv
module icap_edge
   import icap_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      lvl_i,
   input  edge_sel_e sel_i,
   output logic      evt_o
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= lvl_i;
   end

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;

   always_comb begin
      unique case (sel_i)
         EDGE_RISE: evt_o = rise;
         EDGE_FALL: evt_o = fall;
         EDGE_BOTH: evt_o = rise | fall;
         default:   evt_o = 1'b0;
      endcase
   end

   // R4: a disabled qualifier never yields an event
   assert_off_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == EDGE_OFF) |-> !evt_o);
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [WIDTH-1:0] cnt_o
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   if (WIDTH < 2) begin : g_bad
      $error("icap_counter: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_q + ONE;
   end

   assign cnt_o = cnt_q;

   assert_count_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> cnt_q == $past(cnt_q) + ONE);
endmodule

// File: rtl/icap_buffered.sv
module icap_buffered
   import icap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             pin_i,
   input  logic [1:0]       edge_sel_i,
   input  logic             buf_en_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic [CNT_W-1:0] buf_o,
   output logic             evt_o,
   output logic             seen_o
);
   logic             pin_s;
   logic             evt;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cap_q, buf_q;
   logic             pulse_q, seen_q;

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_i(rst_i), .d_i(pin_i), .q_o(pin_s));

   icap_edge u_edge (
      .clk_i(clk_i), .rst_i(rst_i), .lvl_i(pin_s),
      .sel_i(edge_sel_e'(edge_sel_i)), .evt_o(evt));

   icap_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_i(rst_i), .cnt_o(cnt));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cap_q   <= '0;
         buf_q   <= '0;
         pulse_q <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         pulse_q <= evt;
         if (evt) begin
            cap_q <= cnt;
            if (buf_en_i) buf_q <= cap_q;
         end
         if (evt)        seen_q <= 1'b1;
         else if (clr_i) seen_q <= 1'b0;
      end
   end

   assign cnt_o  = cnt;
   assign cap_o  = cap_q;
   assign buf_o  = buf_q;
   assign evt_o  = pulse_q;
   assign seen_o = seen_q;

   assert_cap_value_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_q |-> cap_q == $past(cnt));
   assert_buf_shift_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (pulse_q && $past(buf_en_i)) |-> buf_q == $past(cap_q));
   assert_buf_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (pulse_q && !$past(buf_en_i)) |-> $stable(buf_q));
   assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      !pulse_q |-> ($stable(cap_q) && $stable(buf_q)));
   assert_sticky_set_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_q |-> seen_q);
endmodule

// File: tb/sim_icap_buffered.sv
module sim_icap_buffered;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pin = 1'b0;
   logic [1:0]  sel = 2'b00;
   logic        ben = 1'b0;
   logic        clr = 1'b0;
   logic [15:0] cnt, cap, bufv;
   logic        evt, seen;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_cap = '0, m_buf = '0;

   always #4 clk = ~clk;   // 125 MHz

   icap_buffered u0 (
      .clk_i(clk), .rst_i(rst), .pin_i(pin), .edge_sel_i(sel),
      .buf_en_i(ben), .clr_i(clr), .cnt_o(cnt), .cap_o(cap),
      .buf_o(bufv), .evt_o(evt), .seen_o(seen));

   // fields: [4:3] edge mode, [2] buffer enable, [1] new pin level, [0] capture expected
   localparam logic [4:0] VEC [10] = '{
      {2'b00, 1'b1, 1'b1, 1'b1},
      {2'b00, 1'b1, 1'b0, 1'b0},
      {2'b01, 1'b1, 1'b1, 1'b0},
      {2'b01, 1'b1, 1'b0, 1'b1},
      {2'b10, 1'b0, 1'b1, 1'b1},
      {2'b10, 1'b1, 1'b0, 1'b1},
      {2'b11, 1'b1, 1'b1, 1'b0},
      {2'b11, 1'b1, 1'b0, 1'b0},
      {2'b10, 1'b1, 1'b1, 1'b1},
      {2'b00, 1'b0, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // toggle pin at a falling edge, then check after the third rising edge
   task automatic stroke(input logic lvl, input logic exp);
      logic [15:0] c;
      c = cnt;
      pin = lvl;
      @(negedge clk); @(negedge clk);
      check("R3/R7 no early strobe", {31'd0, evt}, 32'd0);
      @(negedge clk);
      check("R7 strobe", {31'd0, evt}, {31'd0, exp});
      if (exp) begin
         if (ben) m_buf = m_cap;
         m_cap = c + 16'd2;
      end
      check("R3/R9 capture value", {16'd0, cap}, {16'd0, m_cap});
      check("R5/R6 buffer value", {16'd0, bufv}, {16'd0, m_buf});
      @(negedge clk);
      check("R7 single-cycle strobe", {31'd0, evt}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      // R2: reset state
      repeat (4) @(negedge clk);
      check("R2 count", {16'd0, cnt}, 32'd0);
      check("R2 cap", {16'd0, cap}, 32'd0);
      check("R2 buf", {16'd0, bufv}, 32'd0);
      check("R2 flags", {30'd0, evt, seen}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 first step", {16'd0, cnt}, 32'd1);

      // table walk: R4, R5, R6, R9
      foreach (VEC[i]) begin
         sel = VEC[i][4:3];
         ben = VEC[i][2];
         @(negedge clk);
         stroke(VEC[i][1], VEC[i][0]);
      end

      // R8: sticky status and write-one clear
      check("R8 sticky set", {31'd0, seen}, 32'd1);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      check("R8 cleared", {31'd0, seen}, 32'd0);
      sel = 2'b10; ben = 1'b1;
      pin = ~pin;
      @(negedge clk); @(negedge clk);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      check("R8 set wins over clear", {31'd0, seen}, 32'd1);
      check("R8 event with clear", {31'd0, evt}, 32'd1);
      @(negedge clk);

      // R3/R5: timestamps at 0x0245, 0x5480, 0xDA91 on both edges
      while (cnt != 16'h0243) @(negedge clk);
      pin = ~pin; repeat (4) @(negedge clk);
      check("R3 first stamp", {16'd0, cap}, 32'h0245);
      while (cnt != 16'h547E) @(negedge clk);
      pin = ~pin; repeat (4) @(negedge clk);
      check("R5 buffer after second", {16'd0, bufv}, 32'h0245);
      while (cnt != 16'hDA8F) @(negedge clk);
      pin = ~pin; repeat (4) @(negedge clk);
      check("R3 third stamp", {16'd0, cap}, 32'hDA91);
      check("R5 buffer after third", {16'd0, bufv}, 32'h5480);

      // R1: wrap
      while (cnt != 16'hFFFF) @(negedge clk);
      @(negedge clk);
      check("R1 wrap", {16'd0, cnt}, 32'd0);
      summary();
   end
endmodule